// File: doc/BRIEF.md
# SD Card Clock Divider and Data Timeout Timer

This block derives the card-side clock of an SD/MMC host from the peripheral clock and times the data phase of a transfer. A 32-bit timing word holds three fields: a 16-bit timeout count, an 8-bit even divide value and an 8-bit rate value. The card clock runs at the source rate divided by `divide * (rate + 1)`. It is built from two counting stages: a prescaler that ticks every `divide/2` source cycles, and a rate stage that toggles the card clock after `rate + 1` such ticks.

New divider settings are picked up only at the end of a low phase, which is the point where the card clock is about to rise. The clock therefore never produces a runt pulse. A one-cycle `card_rise` strobe marks each rising card clock edge, and the timeout timer counts those strobes.

The command and data engines around the block only start, reload and stop the timer. The timer is armed at the start of a data phase and counts in units of a fixed number of card clocks (4096 by default). When the count runs out it emits a one-cycle pulse. That pulse is reported either as a receive timeout or as a data timeout, according to the direction latched when the phase started.

Top module: `sd_clk_timer`

## Requirements
- R1: After reset the timing word reads 0xFFFF0200 (timeout 0xFFFF, divide 2, rate 0), `card_clk` is low and both timeout outputs are low. The card clock then runs with a period of 2 source cycles.
- R2: The card clock period is `divide * (rate + 1)` source cycles, and `card_clk` is high for exactly half of each period.
- R3: An odd divide value is rounded down to the next even value. A divide value that rounds to 0 (0 or 1) is treated as 2.
- R4: A write with `cfg_we` high stores `cfg_wdata` and is visible on `timing_q` in the next cycle. The fields are: timeout in bits [31:16], divide in bits [15:8] and rate in bits [7:0].
- R5: A divider change takes effect only at the next rising card clock edge. The period in progress completes with the old settings.
- R6: `card_rise` is high for exactly one cycle: the first cycle in which `card_clk` is high in each period.
- R7: Once armed by `data_start`, the timer fires after T×4096 counted `card_rise` strobes, where T is the timeout field. The pulse comes one cycle after the last counted strobe. T = 0 fires on the first strobe. A strobe in the cycle where `data_start` is high is not counted.
- R8: If `data_is_read` was high at `data_start`, the expiry pulses `rx_tmo`. Otherwise it pulses `data_tmo`. The two are never high together.
- R9: `block_done` while armed restarts the full count from the current timeout field. A strobe in the `block_done` cycle is not counted.
- R10: `data_stop` disarms the timer and takes priority over `data_start` in the same cycle. No timeout pulse follows.
- R11: Each expiry is a single one-cycle pulse, after which the timer stays disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral (source) clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_wdata | input | 32 | Timing word write data |
| timing_q | output | 32 | Current timing word |
| data_start | input | 1 | Arm the timer at the start of a data phase |
| data_is_read | input | 1 | Direction of the starting phase (1 = card to host) |
| block_done | input | 1 | Reload the timer after a finished block |
| data_stop | input | 1 | Disarm the timer |
| card_clk | output | 1 | Divided card clock level |
| card_rise | output | 1 | One-cycle strobe on each card clock rising edge |
| data_tmo | output | 1 | Data timeout pulse (write phase) |
| rx_tmo | output | 1 | Receive timeout pulse (read phase) |

## Verification
The hardest situation to create is a divider rewrite that lands in the middle of a running period. The bench waits for a `card_rise` strobe with an 18-cycle setting active and writes a 4-cycle setting in that same cycle. It then counts cycles to the next strobe, expecting the old 18, and then the following interval, expecting the new 4. The reload and exact-count checks on the timer are also hard to reach through the ports. These run with the fastest divider so that thousands of card edges pass in a short run, and the bench counts each strobe itself so that the pulse can be matched to the exact strobe.

// File: rtl/sdct_pkg.sv
package sdct_pkg;

  typedef struct packed {
    logic [15:0] tmo;
    logic [7:0]  div;
    logic [7:0]  rate;
  } timing_t;

  localparam timing_t TIMING_RST = '{tmo: 16'hFFFF, div: 8'd2, rate: 8'd0};

  // Half of the sanitized even divide value (1..127).
  function automatic logic [6:0] half_of(input logic [7:0] d);
    logic [7:0] e;
    e = {d[7:1], 1'b0};
    if (e == 8'd0) e = 8'd2;
    return e[7:1];
  endfunction

endpackage

// File: rtl/sdct_prescale.sv
module sdct_prescale #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] half,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = (cnt >= half - W'(1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/sdct_rate.sv
module sdct_rate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] rate,
  output logic         toggle
);
  logic [W-1:0] rcnt;

  assign toggle = tick && (rcnt >= rate);

  always_ff @(posedge clk) begin
    if (rst)         rcnt <= '0;
    else if (toggle) rcnt <= '0;
    else if (tick)   rcnt <= rcnt + W'(1);
  end
endmodule

// File: rtl/sdct_timer.sv
module sdct_timer #(
  parameter int UNIT_TICKS = 4096,
  parameter int UNIT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_read,
  input  logic              reload,
  input  logic              stop,
  input  logic [UNIT_W-1:0] units_in,
  input  logic              rise,
  output logic              data_tmo,
  output logic              rx_tmo
);
  localparam int SUB_W = $clog2(UNIT_TICKS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT_TICKS - 1);

  logic              armed, rd;
  logic [UNIT_W-1:0] units;
  logic [SUB_W-1:0]  sub;
  logic              last_tick;

  assign last_tick = (units == '0) || (units == UNIT_W'(1) && sub == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      rd       <= 1'b0;
      units    <= '0;
      sub      <= '0;
      data_tmo <= 1'b0;
      rx_tmo   <= 1'b0;
    end else begin
      data_tmo <= 1'b0;
      rx_tmo   <= 1'b0;
      if (stop) begin
        armed <= 1'b0;
      end else if (start) begin
        armed <= 1'b1;
        rd    <= is_read;
        units <= units_in;
        sub   <= '0;
      end else if (armed && reload) begin
        units <= units_in;
        sub   <= '0;
      end else if (armed && rise) begin
        if (last_tick) begin
          armed <= 1'b0;
          if (rd) rx_tmo   <= 1'b1;
          else    data_tmo <= 1'b1;
        end else if (sub == SUB_LAST) begin
          sub   <= '0;
          units <= units - UNIT_W'(1);
        end else begin
          sub <= sub + SUB_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sd_clk_timer.sv
module sd_clk_timer #(
  parameter int UNIT_TICKS = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] timing_q,
  input  logic        data_start,
  input  logic        data_is_read,
  input  logic        block_done,
  input  logic        data_stop,
  output logic        card_clk,
  output logic        card_rise,
  output logic        data_tmo,
  output logic        rx_tmo
);
  import sdct_pkg::*;

  timing_t    cfg_q;
  logic [6:0] act_half;
  logic [7:0] act_rate;
  logic       tick, toggle;
  logic       clk_r, rise_r;

  assign timing_q  = cfg_q;
  assign card_clk  = clk_r;
  assign card_rise = rise_r;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= TIMING_RST;
    else if (cfg_we) cfg_q <= timing_t'(cfg_wdata);
  end

  sdct_prescale #(.W(7)) u_pre (
    .clk(clk), .rst(rst), .half(act_half), .tick(tick)
  );

  sdct_rate #(.W(8)) u_rate (
    .clk(clk), .rst(rst), .tick(tick), .rate(act_rate), .toggle(toggle)
  );

  // Settings are taken only as the low phase ends, with both stages at zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_half <= half_of(TIMING_RST.div);
      act_rate <= TIMING_RST.rate;
      clk_r    <= 1'b0;
      rise_r   <= 1'b0;
    end else begin
      rise_r <= toggle && !clk_r;
      if (toggle) clk_r <= !clk_r;
      if (toggle && !clk_r) begin
        act_half <= half_of(cfg_q.div);
        act_rate <= cfg_q.rate;
      end
    end
  end

  sdct_timer #(.UNIT_TICKS(UNIT_TICKS), .UNIT_W(16)) u_tmr (
    .clk(clk), .rst(rst), .start(data_start), .is_read(data_is_read),
    .reload(block_done), .stop(data_stop), .units_in(cfg_q.tmo),
    .rise(rise_r), .data_tmo(data_tmo), .rx_tmo(rx_tmo)
  );
endmodule

// File: rtl/sd_clk_timer_chk.sv
module sd_clk_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] timing_q,
  input logic        data_stop,
  input logic        card_clk,
  input logic        card_rise,
  input logic        data_tmo,
  input logic        rx_tmo
);
  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    card_rise |-> (card_clk && !$past(card_clk)));                    // R6
  AST_EDGE_HAS_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(card_clk) |-> card_rise);                                   // R6
  AST_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_tmo, rx_tmo}));                                    // R8
  AST_TMO_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    (data_tmo || rx_tmo) |-> $past(card_rise));                       // R7
  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (data_tmo || rx_tmo) |=> !(data_tmo || rx_tmo));                  // R11
  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    data_stop |=> !(data_tmo || rx_tmo));                             // R10
  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (timing_q == $past(cfg_wdata)));                       // R4
endmodule

bind sd_clk_timer sd_clk_timer_chk u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .timing_q(timing_q), .data_stop(data_stop), .card_clk(card_clk),
  .card_rise(card_rise), .data_tmo(data_tmo), .rx_tmo(rx_tmo)
);

// File: tb/tb_sd_clk_timer.sv
`timescale 1ns/1ps
module tb_sd_clk_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] timing_q;
  logic        data_start = 1'b0, data_is_read = 1'b0;
  logic        block_done = 1'b0, data_stop = 1'b0;
  logic        card_clk, card_rise, data_tmo, rx_tmo;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sd_clk_timer dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .timing_q(timing_q), .data_start(data_start), .data_is_read(data_is_read),
    .block_done(block_done), .data_stop(data_stop), .card_clk(card_clk),
    .card_rise(card_rise), .data_tmo(data_tmo), .rx_tmo(rx_tmo)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] t, input logic [7:0] d, input logic [7:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {t, d, r};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!card_rise);
  endtask

  // Skips one rise (old settings may still be active), then measures one period.
  task automatic measure(input int exp_p, input string req);
    int n, hi;
    wait_rise();
    wait_rise();
    n = 0; hi = 1;
    do begin
      @(negedge clk); n++;
      if (card_clk && !card_rise) hi++;
    end while (!card_rise && n < 5000);
    chk(n == exp_p, {req, " period"}, n, exp_p);
    chk(hi == exp_p / 2, {req, " high time"}, hi, exp_p / 2);
  endtask

  task automatic test_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(timing_q == 32'hFFFF0200, "R1 timing reset", timing_q, 32'hFFFF0200);
    chk(!card_clk && !data_tmo && !rx_tmo, "R1 outputs low", {card_clk, data_tmo, rx_tmo}, 0);
    measure(2, "R1");
  endtask

  task automatic test_divider();
    write_cfg(16'hFFFF, 8'd6, 8'd2);   measure(18, "R2 d6r2");
    write_cfg(16'hFFFF, 8'd2, 8'd255); measure(512, "R2 d2r255");
    write_cfg(16'hFFFF, 8'd254, 8'd3); measure(1016, "R2 d254r3");
    write_cfg(16'hFFFF, 8'd7, 8'd0);   measure(6, "R3 odd d7");
    write_cfg(16'hFFFF, 8'd0, 8'd1);   measure(4, "R3 zero d0");
    write_cfg(16'hFFFF, 8'd1, 8'd0);   measure(2, "R3 one d1");
  endtask

  task automatic test_fields();
    write_cfg(16'h1234, 8'd10, 8'd5);
    chk(timing_q == 32'h12340A05, "R4 readback", timing_q, 32'h12340A05);
    measure(60, "R4 field placement");
  endtask

  task automatic test_switch();
    int n;
    write_cfg(16'hFFFF, 8'd6, 8'd2);
    wait_rise(); wait_rise();
    cfg_we = 1'b1; cfg_wdata = {16'hFFFF, 8'd4, 8'd0};
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) cfg_we = 1'b0;
    end while (!card_rise && n < 100);
    chk(n == 18, "R5 old period completes", n, 18);
    n = 0;
    do begin @(negedge clk); n++; end while (!card_rise && n < 100);
    chk(n == 4, "R5 new period after edge", n, 4);
  endtask

  task automatic test_rise_pulse();
    int w;
    write_cfg(16'hFFFF, 8'd4, 8'd1);
    wait_rise();
    chk(card_clk == 1'b1, "R6 rise with clock high", card_clk, 1);
    @(negedge clk);
    chk(card_rise == 1'b0 && card_clk == 1'b1, "R6 single-cycle strobe", card_rise, 0);
    w = 0;
    while (card_clk) begin @(negedge clk); w++; end
    chk(w == 3, "R6 remaining high cycles", w, 3);
  endtask

  // Arms the timer, optionally reloads it, and counts strobes to the pulse.
  task automatic run_tmo(input logic [15:0] t, input bit rd, input int reload_at,
                         input int exp_rises, input string req);
    int rises, n;
    bit reloaded, fired_rx, fired_dt;
    write_cfg(t, 8'd2, 8'd0);
    @(negedge clk); data_start = 1'b1; data_is_read = rd;
    @(negedge clk); data_start = 1'b0;
    rises = 0; reloaded = 1'b0; fired_rx = 1'b0; fired_dt = 1'b0; n = 0;
    while (n < 60000) begin
      block_done = 1'b0;
      if (data_tmo || rx_tmo) begin
        fired_rx = rx_tmo; fired_dt = data_tmo;
        break;
      end
      if (card_rise) rises++;
      if (reload_at != 0 && rises == reload_at && !reloaded) begin
        block_done = 1'b1; reloaded = 1'b1;
      end
      @(negedge clk); n++;
    end
    block_done = 1'b0;
    chk(rises == exp_rises, {req, " strobes to expiry"}, rises, exp_rises);
    chk(fired_rx == rd && fired_dt == !rd, "R8 direction of pulse",
        {fired_rx, fired_dt}, {rd, !rd});
    n = 0;
    repeat (40) begin @(negedge clk); if (data_tmo || rx_tmo) n++; end
    chk(n == 0, "R11 no repeat pulse", n, 0);
  endtask

  task automatic test_stop();
    int n;
    write_cfg(16'd1, 8'd2, 8'd0);
    @(negedge clk); data_start = 1'b1; data_stop = 1'b1;
    @(negedge clk); data_start = 1'b0; data_stop = 1'b0;
    n = 0;
    repeat (9000) begin @(negedge clk); if (data_tmo || rx_tmo) n++; end
    chk(n == 0, "R10 stop beats start", n, 0);
    @(negedge clk); data_start = 1'b1; data_is_read = 1'b1;
    @(negedge clk); data_start = 1'b0;
    repeat (100) @(negedge clk);
    data_stop = 1'b1;
    @(negedge clk); data_stop = 1'b0;
    n = 0;
    repeat (9000) begin @(negedge clk); if (data_tmo || rx_tmo) n++; end
    chk(n == 0, "R10 stop while armed", n, 0);
  endtask

  initial begin
    #(20ns * 190000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_divider();
    test_fields();
    test_switch();
    test_rise_pulse();
    run_tmo(16'd0, 1'b1, 0, 1, "R7 T0 read");
    run_tmo(16'd1, 1'b0, 0, 4096, "R7 T1 write");
    run_tmo(16'd1, 1'b1, 3000, 3000 + 4096, "R9 reload");
    test_stop();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule